// File: doc/BRIEF.md
# Scratchpad Operand Address Generator

This block turns register values and instruction mask fields into the two scratchpad byte addresses a virtual-machine instruction needs: the location its source operand is loaded from and the location its result is stored to. The scratchpad is 256 KiB of 8-byte words. A 2-bit width selector on each side picks either the full 15-bit word index or an 11-bit index that stays inside the first 16 KiB.

The load side is destructive. The source register is XORed with its sign-extended 32-bit mask, and that new value is handed back for write-back to the register file. The low 32 bits of the new value form the raw load address. Unless the instruction opts out, the raw address is folded by XOR into an internal 64-bit mixing accumulator, before any truncation. The low bits of the instruction counter also decide whether this instruction must fetch from the large dataset. This happens once in every 64 instructions. The store side leaves its base register alone. It XORs the base register's low word with the instruction's 32-bit immediate and truncates the result.

A strobe presents one instruction. All results, and the accumulator update, appear after the next rising clock edge. The register file, the memories and the dataset sit outside the block.

Top module: `spad_addr_gen`

## Requirements
- R1: After a synchronous reset, rsp_valid, ds_fetch, rd_byte_addr, wr_byte_addr, rd_reg_next and mix_reg are all zero.
- R2: One cycle after a strobe, rd_reg_next equals rd_src_reg XOR the 64-bit sign extension of rd_mask (bit 31 of the mask copied into bits 63:32).
- R3: One cycle after a strobe, rd_byte_addr equals 8 times the low 15 bits of rd_reg_next[31:0] when rd_width_sel is 0, and 8 times the low 11 bits when rd_width_sel is 1, 2 or 3. The result is therefore always 8-byte aligned and below 16384 for the narrow settings.
- R4: On a strobe with rd_mix_off = 0, mix_reg becomes its old value XOR the zero-extended 32-bit raw load address (rd_reg_next[31:0], not truncated). With rd_mix_off = 1, mix_reg keeps its value.
- R5: One cycle after a strobe, ds_fetch is 1 exactly when the 6 instruction-counter bits given were all zero, i.e. the counter is a multiple of 64.
- R6: One cycle after a strobe, wr_byte_addr equals 8 times the low 15 bits (wr_width_sel = 0) or the low 11 bits (wr_width_sel = 1..3) of wr_base_reg XOR wr_mask.
- R7: rsp_valid is 1 in exactly the cycle after each strobe. In a cycle with no strobe, mix_reg does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One instruction presented this cycle |
| instr_cnt | input | 6 | Low bits of the instruction counter |
| rd_src_reg | input | 64 | Load-address source register value |
| rd_mask | input | 32 | Load address mask |
| rd_width_sel | input | 2 | Load index width: 0 = 15 bits, 1..3 = 11 bits |
| rd_mix_off | input | 1 | 1 suppresses accumulator mixing |
| wr_base_reg | input | 32 | Low word of the store-address register |
| wr_mask | input | 32 | Store address immediate |
| wr_width_sel | input | 2 | Store index width: 0 = 15 bits, 1..3 = 11 bits |
| rsp_valid | output | 1 | Results below are for the previous strobe |
| rd_byte_addr | output | 18 | Load byte address |
| rd_reg_next | output | 64 | Updated source register for write-back |
| wr_byte_addr | output | 18 | Store byte address |
| ds_fetch | output | 1 | Dataset read required |
| mix_reg | output | 64 | Mixing accumulator |

## Verification
On every cycle, the embedded properties check the one-cycle strobe-to-response relation, the 8-byte alignment of both addresses, the 16 KiB bound under the narrow width settings, the dataset flag against the sampled counter bits, and that the accumulator holds whenever mixing is off or no strobe arrives. The exact address and write-back values, the XOR history built up in the accumulator over a long run, and the sign extension of masks with bit 31 set can only be shown by the bench. It sweeps every width pair, both mixing settings and a range of counter values, and compares against arithmetic it computes itself.

// File: rtl/spad_addr_pkg.sv
package spad_addr_pkg;

    localparam int REG_W       = 64;
    localparam int RAW_W       = 32;
    localparam int WIDE_IDX    = 15;
    localparam int NARROW_IDX  = 11;
    localparam int ALIGN_SH    = 3;
    localparam int DS_LOG      = 6;
    localparam int MIX_W       = 64;

    localparam int BYTE_W      = WIDE_IDX + ALIGN_SH;
    localparam int NARROW_SPAN = (1 << (NARROW_IDX + ALIGN_SH));
    localparam logic [WIDE_IDX-1:0] NARROW_KEEP = WIDE_IDX'((1 << NARROW_IDX) - 1);

    typedef logic [1:0]        width_sel_t;
    typedef logic [BYTE_W-1:0] byte_addr_t;

    typedef struct packed {
        logic [REG_W-1:0] reg_next;
        logic [RAW_W-1:0] raw;
        byte_addr_t       addr;
    } load_calc_t;

    typedef struct packed {
        logic             valid;
        logic             ds;
        byte_addr_t       rd_addr;
        byte_addr_t       wr_addr;
        logic [REG_W-1:0] reg_next;
    } rsp_t;

    function automatic logic [REG_W-1:0] sext_mask(input logic [RAW_W-1:0] m);
        return {{(REG_W-RAW_W){m[RAW_W-1]}}, m};
    endfunction

    // Width selector 0 keeps the full index; any other code keeps the narrow one.
    function automatic byte_addr_t index_to_byte(input logic [WIDE_IDX-1:0] idx_full,
                                                 input width_sel_t ws);
        logic [WIDE_IDX-1:0] idx;
        idx = (ws == 2'd0) ? idx_full : (idx_full & NARROW_KEEP);
        return {idx, {ALIGN_SH{1'b0}}};
    endfunction

endpackage

// File: rtl/spad_rd_path.sv
module spad_rd_path
    import spad_addr_pkg::*;
(
    input  logic [REG_W-1:0] src_reg,
    input  logic [RAW_W-1:0] mask,
    input  width_sel_t       width_sel,
    output load_calc_t       calc
);
    logic [REG_W-1:0] updated;

    always_comb begin
        updated       = src_reg ^ sext_mask(mask);
        calc.reg_next = updated;
        calc.raw      = updated[RAW_W-1:0];
        calc.addr     = index_to_byte(updated[WIDE_IDX-1:0], width_sel);
    end

    always_comb begin
        if (width_sel != 2'd0)
            a_rd_narrow_r3: assert (int'(calc.addr) < NARROW_SPAN);
    end
endmodule

// File: rtl/spad_wr_path.sv
module spad_wr_path
    import spad_addr_pkg::*;
(
    input  logic [RAW_W-1:0] base_lo,
    input  logic [RAW_W-1:0] mask,
    input  width_sel_t       width_sel,
    output byte_addr_t       addr
);
    logic [RAW_W-1:0] mixed;

    always_comb begin
        mixed = base_lo ^ mask;
        addr  = index_to_byte(mixed[WIDE_IDX-1:0], width_sel);
    end

    always_comb begin
        if (width_sel != 2'd0)
            a_wr_narrow_r6: assert (int'(addr) < NARROW_SPAN);
    end
endmodule

// File: rtl/spad_mix_acc.sv
module spad_mix_acc
    import spad_addr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic             mix_off,
    input  logic [RAW_W-1:0] raw,
    output logic [MIX_W-1:0] acc
);
    logic [MIX_W-1:0] fold;

    generate
        if (MIX_W > RAW_W) begin : g_ext
            assign fold = {{(MIX_W-RAW_W){1'b0}}, raw};
        end else begin : g_trunc
            assign fold = raw[MIX_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (fire && !mix_off)
            acc <= acc ^ fold;
    end

    p_mix_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (fire && mix_off) |=> $stable(acc));
    p_mix_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(acc));
    p_mix_fold_r4: assert property (@(posedge clk) disable iff (rst)
        (fire && !mix_off) |=> (acc == ($past(acc) ^ $past(fold))));
endmodule

// File: rtl/spad_addr_gen.sv
module spad_addr_gen
    import spad_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [DS_LOG-1:0] instr_cnt,
    input  logic [REG_W-1:0]  rd_src_reg,
    input  logic [RAW_W-1:0]  rd_mask,
    input  logic [1:0]        rd_width_sel,
    input  logic              rd_mix_off,
    input  logic [RAW_W-1:0]  wr_base_reg,
    input  logic [RAW_W-1:0]  wr_mask,
    input  logic [1:0]        wr_width_sel,
    output logic              rsp_valid,
    output logic [BYTE_W-1:0] rd_byte_addr,
    output logic [REG_W-1:0]  rd_reg_next,
    output logic [BYTE_W-1:0] wr_byte_addr,
    output logic              ds_fetch,
    output logic [MIX_W-1:0]  mix_reg
);
    load_calc_t ld;
    byte_addr_t st_addr;
    rsp_t       rsp_q;

    spad_rd_path u_rd (
        .src_reg   (rd_src_reg),
        .mask      (rd_mask),
        .width_sel (rd_width_sel),
        .calc      (ld)
    );

    spad_wr_path u_wr (
        .base_lo   (wr_base_reg),
        .mask      (wr_mask),
        .width_sel (wr_width_sel),
        .addr      (st_addr)
    );

    spad_mix_acc u_mix (
        .clk     (clk),
        .rst     (rst),
        .fire    (req_valid),
        .mix_off (rd_mix_off),
        .raw     (ld.raw),
        .acc     (mix_reg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= req_valid;
            if (req_valid) begin
                rsp_q.ds       <= (instr_cnt == '0);
                rsp_q.rd_addr  <= ld.addr;
                rsp_q.wr_addr  <= st_addr;
                rsp_q.reg_next <= ld.reg_next;
            end
        end
    end

    assign rsp_valid    = rsp_q.valid;
    assign ds_fetch     = rsp_q.ds;
    assign rd_byte_addr = rsp_q.rd_addr;
    assign wr_byte_addr = rsp_q.wr_addr;
    assign rd_reg_next  = rsp_q.reg_next;

    p_rsp_follow_r7: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_rsp_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    p_ds_period_r5: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (ds_fetch == ($past(instr_cnt) == '0)));
    p_align_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rd_byte_addr[ALIGN_SH-1:0] == '0 && wr_byte_addr[ALIGN_SH-1:0] == '0));
    p_rd_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rd_width_sel != 2'd0) |=> (int'(rd_byte_addr) < NARROW_SPAN));
    p_wr_bound_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && wr_width_sel != 2'd0) |=> (int'(wr_byte_addr) < NARROW_SPAN));
endmodule

// File: tb/tb_spad_addr_gen.sv
`timescale 1ns/1ps
module tb_spad_addr_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [5:0]  instr_cnt;
    logic [63:0] rd_src_reg;
    logic [31:0] rd_mask;
    logic [1:0]  rd_width_sel;
    logic        rd_mix_off;
    logic [31:0] wr_base_reg;
    logic [31:0] wr_mask;
    logic [1:0]  wr_width_sel;
    logic        rsp_valid;
    logic [17:0] rd_byte_addr;
    logic [63:0] rd_reg_next;
    logic [17:0] wr_byte_addr;
    logic        ds_fetch;
    logic [63:0] mix_reg;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    logic [63:0] mix_model = 64'd0;
    logic [63:0] seed = 64'h0123_4567_89ab_cdef;

    always #2.5 clk = ~clk;

    spad_addr_gen dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] byte_of(input logic [31:0] raw, input logic [1:0] ws);
        longint unsigned idx;
        idx = (ws == 2'd0) ? (longint'(raw) % 32768) : (longint'(raw) % 2048);
        return 64'(idx * 8);
    endfunction

    task automatic run_one(input logic [63:0] rs, input logic [31:0] rm, input logic [1:0] rws,
                           input logic nomix, input logic [31:0] wb, input logic [31:0] wm,
                           input logic [1:0] wws, input logic [5:0] cnt);
        logic [63:0] exp_next;
        logic [63:0] exp_wr;
        @(negedge clk);
        req_valid = 1; rd_src_reg = rs; rd_mask = rm; rd_width_sel = rws; rd_mix_off = nomix;
        wr_base_reg = wb; wr_mask = wm; wr_width_sel = wws; instr_cnt = cnt;
        exp_next = rs ^ {{32{rm[31]}}, rm};
        exp_wr   = byte_of(wb ^ wm, wws);
        if (!nomix) mix_model = mix_model ^ {32'd0, exp_next[31:0]};
        @(posedge clk); #1;
        req_valid = 0;
        chk(rsp_valid == 1'b1, "R7 valid after strobe", 64'(rsp_valid), 64'd1);
        chk(rd_reg_next == exp_next, "R2 write-back value", rd_reg_next, exp_next);
        chk(64'(rd_byte_addr) == byte_of(exp_next[31:0], rws), "R3 load address",
            64'(rd_byte_addr), byte_of(exp_next[31:0], rws));
        chk(64'(wr_byte_addr) == exp_wr, "R6 store address", 64'(wr_byte_addr), exp_wr);
        chk(ds_fetch == (cnt % 64 == 0), "R5 dataset flag", 64'(ds_fetch), 64'(cnt % 64 == 0));
        chk(mix_reg == mix_model, "R4 mixing accumulator", mix_reg, mix_model);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; req_valid = 0; instr_cnt = 6'd1; rd_src_reg = '1; rd_mask = '1;
        rd_width_sel = 0; rd_mix_off = 0; wr_base_reg = '1; wr_mask = 0; wr_width_sel = 0;
        repeat (3) @(posedge clk);
        #1;
        chk(rsp_valid == 0 && ds_fetch == 0, "R1 reset flags", 64'({rsp_valid, ds_fetch}), 64'd0);
        chk(mix_reg == 0, "R1 reset accumulator", mix_reg, 64'd0);
        chk(rd_byte_addr == 0 && wr_byte_addr == 0, "R1 reset addresses",
            64'({rd_byte_addr, wr_byte_addr}), 64'd0);
        chk(rd_reg_next == 0, "R1 reset write-back", rd_reg_next, 64'd0);
        @(negedge clk); rst = 0;

        // Directed corners: sign extension, full index ends, narrow truncation.
        run_one(64'h0, 32'h8000_0000, 2'd0, 0, 32'h0000_7fff, 32'h0, 2'd0, 6'd0);
        run_one(64'hffff_ffff_ffff_ffff, 32'h7fff_ffff, 2'd1, 0, 32'hffff_ffff, 32'h0, 2'd3, 6'd63);
        run_one(64'h1234_5678_0000_7fff, 32'h0, 2'd0, 1, 32'h0000_07ff, 32'h0000_0800, 2'd2, 6'd32);
        run_one(64'h0000_0000_0000_ffff, 32'hffff_8000, 2'd2, 0, 32'haaaa_5555, 32'h5555_aaaa, 2'd1, 6'd0);

        // Idle cycle: no response, accumulator unchanged (R7).
        @(negedge clk);
        rd_mix_off = 0; rd_src_reg = 64'hdead_beef_dead_beef;
        @(posedge clk); #1;
        chk(rsp_valid == 0, "R7 no strobe no response", 64'(rsp_valid), 64'd0);
        chk(mix_reg == mix_model, "R7 idle accumulator held", mix_reg, mix_model);

        // Sweep all width pairs, both mixing settings, varied counters and data.
        for (int i = 0; i < 256; i++) begin
            seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
            run_one({seed[31:0], seed[63:32]}, seed[63:32], 2'(i), 1'(i >> 4),
                    seed[47:16], seed[31:0] ^ 32'h9e37_79b9, 2'(i >> 2), 6'(i * 16));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule